// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block keeps the position of a 16-step wiper as a 4-bit code and lets a board-level controller move it through three slow control lines: an active-low select, an active-low step strobe and a direction level. While the block is selected, every falling edge of the strobe moves the code one position in the chosen direction. The code stops at both ends and never wraps. The code goes out on a plain output bus, which feeds whatever ladder or DAC sits downstream.

The block also holds a modelled non-volatile word. Releasing the select line while the strobe rests high saves the present code into that word. Releasing it while the strobe is low abandons the session and saves nothing. A save raises a busy flag for a parameterised number of clocks, which stands in for the program time. During that interval the block ignores step edges. Power-on reset clears the word to a parameterised default and loads that default into the code. A synchronous soft reset reloads the code from the saved word and leaves the word untouched.

All three control lines pass through two-flop synchronizers. Edges are found by comparing each synchronized sample with the one before it.

Top module: `wiper_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low, then released) `tap_code` equals the low 4 bits of `NV_DEFAULT` (default 5) and `busy` is 0. Power-on reset also discards any previously saved word.
- R2: With `cs_n` low and `busy` 0, each high-to-low transition of `inc_n` changes `tap_code` by exactly one position. A low-to-high transition of `inc_n` changes nothing. The new code is visible within four clock cycles of the edge.
- R3: `up_dn` = 1 at the falling strobe edge increments the code, and `up_dn` = 0 decrements it.
- R4: At code 15, further up steps leave the code at 15.
- R5: At code 0, further down steps leave the code at 0.
- R6: While `cs_n` is high, strobe and direction activity leaves `tap_code` unchanged.
- R7: A low-to-high transition of `cs_n` while `inc_n` is high saves the present code into the non-volatile word. The upper 4 bits of the 8-bit word are stored as zero.
- R8: A low-to-high transition of `cs_n` while `inc_n` is low saves nothing and leaves `busy` at 0.
- R9: A save holds `busy` at 1 for exactly `STORE_CYCLES` clock cycles. While `busy` is 1, strobe edges do not move the code.
- R10: A one-cycle pulse on `soft_rst` loads the saved word's low 4 bits into `tap_code` and keeps the saved word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| soft_rst | input | 1 | Synchronous soft reset, active high; recalls the saved word |
| cs_n | input | 1 | Active-low select, asynchronous to `clk` |
| inc_n | input | 1 | Step strobe; the falling edge moves the wiper |
| up_dn | input | 1 | Direction: 1 = up, 0 = down |
| tap_code | output | TAP_W | Current wiper code |
| busy | output | 1 | High while a save is in progress |

## Verification
A table of strobe pulses is applied with the block selected. It alternates runs of up and down steps through the middle of the range, which separates a correct one-step move from a double step, a step on the rising edge or an inverted direction. Directed sequences then push past both ends to catch wrapping. They end sessions with the strobe high and with it low, and read the outcome only through a soft-reset recall, which distinguishes a real save from a skipped one. Strobe pulses are also applied while deselected and during the busy interval, where any change of the code shows a missing gate. A final power-on reset shows that the saved word returns to its default.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  // positions of the control lines inside the synchronized vector
  localparam int CTL_CS  = 0;
  localparam int CTL_INC = 1;
  localparam int CTL_DIR = 2;
  localparam int CTL_W   = 3;
  // idle levels of the control lines: select high, strobe high, direction low
  localparam logic [CTL_W-1:0] CTL_IDLE = 3'b011;
endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int               W       = 3,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        sync_q <= RST_VAL[b];
      end else begin
        meta_q <= d[b];
        sync_q <= meta_q;
      end
    end
    assign q[b] = sync_q;
  end
endmodule

// File: rtl/wiper_step.sv
module wiper_step #(
  parameter int               TAP_W    = 4,
  parameter logic [TAP_W-1:0] RST_CODE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAP_W-1:0] load_code,
  input  logic             step_en,
  input  logic             step_up,
  output logic [TAP_W-1:0] tap
);
  localparam logic [TAP_W-1:0] TOP = '1;
  localparam logic [TAP_W-1:0] BOT = '0;

  logic [TAP_W-1:0] tap_q, tap_nxt;

  always_comb begin
    tap_nxt = tap_q;
    if (load) begin
      tap_nxt = load_code;
    end else if (step_en) begin
      if (step_up && tap_q != TOP)       tap_nxt = tap_q + 1'b1;
      else if (!step_up && tap_q != BOT) tap_nxt = tap_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= RST_CODE;
    else        tap_q <= tap_nxt;
  end

  assign tap = tap_q;

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && !load && tap != TOP) |=> (tap == $past(tap) + 1'b1));
  assert_step_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up && !load && tap != BOT) |=> (tap == $past(tap) - 1'b1));
  assert_sat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && !load && tap == TOP) |=> (tap == TOP));
  assert_sat_bot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up && !load && tap == BOT) |=> (tap == BOT));
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (tap == $past(load_code)));
endmodule

// File: rtl/wiper_nvstore.sv
module wiper_nvstore #(
  parameter int              TAP_W        = 4,
  parameter int              NV_W         = 8,
  parameter int              STORE_CYCLES = 50000,
  parameter logic [NV_W-1:0] NV_DEFAULT   = 8'h05
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             store_req,
  input  logic [TAP_W-1:0] tap,
  output logic [NV_W-1:0]  nv_word,
  output logic             busy
);
  localparam int CNT_W = $clog2(STORE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STORE_CYCLES);
  localparam int PAD_W = NV_W - TAP_W;

  logic [NV_W-1:0]  nv_q, nv_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    nv_nxt = nv_q;
    if (store_req) nv_nxt = {{PAD_W{1'b0}}, tap};
  end

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr)                 cnt_nxt = '0;
    else if (store_req)      cnt_nxt = CNT_LOAD;
    else if (cnt_q != '0)    cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q  <= NV_DEFAULT;
      cnt_q <= '0;
    end else begin
      nv_q  <= nv_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign nv_word = nv_q;
  assign busy    = (cnt_q != '0);

  assert_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> (nv_word == {{PAD_W{1'b0}}, $past(tap)}));
  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !store_req |=> $stable(nv_word));
  assert_busy_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req && !clr) |=> busy);
  assert_busy_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q > 1 && !clr && !store_req) |=> busy);
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int              TAP_W        = 4,
  parameter int              NV_W         = 8,
  parameter int              STORE_CYCLES = 50000,
  parameter logic [NV_W-1:0] NV_DEFAULT   = 8'h05
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             soft_rst,
  input  logic             cs_n,
  input  logic             inc_n,
  input  logic             up_dn,
  output logic [TAP_W-1:0] tap_code,
  output logic             busy
);
  import wiper_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic [CTL_W-1:0] ctl_raw, ctl_s;
  assign ctl_raw[CTL_CS]  = cs_n;
  assign ctl_raw[CTL_INC] = inc_n;
  assign ctl_raw[CTL_DIR] = up_dn;

  wiper_sync #(.W(CTL_W), .RST_VAL(CTL_IDLE)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ctl_raw),
    .q    (ctl_s)
  );

  // previous synchronized samples of select and strobe
  logic cs_prev_q, inc_prev_q, cs_prev_nxt, inc_prev_nxt;
  assign cs_prev_nxt  = ctl_s[CTL_CS];
  assign inc_prev_nxt = ctl_s[CTL_INC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q  <= CTL_IDLE[CTL_CS];
      inc_prev_q <= CTL_IDLE[CTL_INC];
    end else begin
      cs_prev_q  <= cs_prev_nxt;
      inc_prev_q <= inc_prev_nxt;
    end
  end

  logic inc_fall, cs_rise, step_en, store_req, save_busy;
  logic [NV_W-1:0] nv_word;

  assign inc_fall  = inc_prev_q & ~ctl_s[CTL_INC];
  assign cs_rise   = ~cs_prev_q & ctl_s[CTL_CS];
  assign step_en   = inc_fall & ~ctl_s[CTL_CS] & ~save_busy & ~soft_rst;
  assign store_req = cs_rise & ctl_s[CTL_INC] & ~save_busy & ~soft_rst;

  wiper_step #(.TAP_W(TAP_W), .RST_CODE(NV_DEFAULT[TAP_W-1:0])) step_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (soft_rst),
    .load_code(nv_word[TAP_W-1:0]),
    .step_en  (step_en),
    .step_up  (ctl_s[CTL_DIR]),
    .tap      (tap_code)
  );

  wiper_nvstore #(
    .TAP_W(TAP_W), .NV_W(NV_W),
    .STORE_CYCLES(STORE_CYCLES), .NV_DEFAULT(NV_DEFAULT)
  ) nv_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_rst),
    .store_req(store_req),
    .tap      (tap_code),
    .nv_word  (nv_word),
    .busy     (save_busy)
  );

  assign busy = save_busy;

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_s[CTL_CS] && !soft_rst) |=> $stable(tap_code));
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (save_busy && !soft_rst) |=> $stable(tap_code));
  assert_nv_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(save_busy) |-> (nv_word[NV_W-1:TAP_W] == '0));
  assert_no_save_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !ctl_s[CTL_INC] && !save_busy) |=> !save_busy);
endmodule

// File: tb/wiper_ctrl_tb_top.sv
module wiper_ctrl_tb_top;
  localparam int STORE_N = 40;

  logic clk = 1'b0;
  logic por_n, soft_rst, cs_n, inc_n, up_dn;
  logic [3:0] tap_code;
  logic busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wiper_ctrl #(.TAP_W(4), .NV_W(8), .STORE_CYCLES(STORE_N), .NV_DEFAULT(8'h05)) dut_i (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .cs_n(cs_n),
    .inc_n(inc_n), .up_dn(up_dn), .tap_code(tap_code), .busy(busy)
  );

  // {direction, expected code after one pulse}, selected, starting from 5
  localparam logic [4:0] VEC [12] = '{
    {1'b1, 4'd6}, {1'b1, 4'd7}, {1'b1, 4'd8}, {1'b0, 4'd7},
    {1'b0, 4'd6}, {1'b0, 4'd5}, {1'b0, 4'd4}, {1'b1, 4'd5},
    {1'b0, 4'd4}, {1'b0, 4'd3}, {1'b0, 4'd2}, {1'b0, 4'd1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic dir);
    up_dn = dir;
    tick(2);
    inc_n = 1'b0;
    tick(5);
    inc_n = 1'b1;
    tick(5);
  endtask

  task automatic soft_pulse();
    soft_rst = 1'b1;
    tick(1);
    soft_rst = 1'b0;
    tick(2);
  endtask

  initial begin
    tick(100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    por_n = 1'b0; soft_rst = 1'b0; cs_n = 1'b1; inc_n = 1'b1; up_dn = 1'b0;
    tick(3);
    por_n = 1'b1;
    tick(5);
    chk("R1 reset code", tap_code, 5);
    chk("R1 reset busy", busy, 0);

    // select without saving anything
    cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < 12; i++) begin
      pulse(VEC[i][4]);
      chk(VEC[i][4] ? "R2 R3 table up" : "R2 R3 table down", tap_code, VEC[i][3:0]);
    end

    // rising strobe edge alone does nothing (R2)
    up_dn = 1'b1; inc_n = 1'b0; tick(1);
    // the fall above counts; wait and check then rise only
    tick(5);
    chk("R2 fall step", tap_code, 2);
    inc_n = 1'b1; tick(6);
    chk("R2 rise no step", tap_code, 2);

    for (int i = 0; i < 5; i++) pulse(1'b0);
    chk("R5 floor", tap_code, 0);
    pulse(1'b0);
    chk("R5 floor again", tap_code, 0);

    for (int i = 0; i < 18; i++) pulse(1'b1);
    chk("R4 ceiling", tap_code, 15);
    pulse(1'b1);
    chk("R4 ceiling again", tap_code, 15);

    for (int i = 0; i < 7; i++) pulse(1'b0);
    chk("R3 back to 8", tap_code, 8);

    // save 8 and measure busy; pulse the strobe while busy
    begin
      int busy_cnt = 0;
      cs_n = 1'b1;
      for (int i = 0; i < 60; i++) begin
        if (i == 10) begin cs_n = 1'b0; up_dn = 1'b1; end
        if (i == 12) inc_n = 1'b0;
        if (i == 18) inc_n = 1'b1;
        if (i == 24) inc_n = 1'b0;
        if (i == 30) inc_n = 1'b1;
        tick(1);
        if (busy) busy_cnt++;
      end
      chk("R9 busy length", busy_cnt, STORE_N);
    end
    chk("R9 steps ignored while busy", tap_code, 8);
    chk("R9 busy clear", busy, 0);

    pulse(1'b0);
    pulse(1'b0);
    chk("R3 down to 6", tap_code, 6);
    soft_pulse();
    chk("R7 R10 recall saved", tap_code, 8);

    // end a session with the strobe low: no save
    up_dn = 1'b0; inc_n = 1'b0; tick(6);
    chk("R2 step to 7", tap_code, 7);
    cs_n = 1'b1;
    begin
      int busy_seen = 0;
      for (int i = 0; i < 12; i++) begin
        tick(1);
        if (busy) busy_seen++;
      end
      chk("R8 no busy", busy_seen, 0);
    end
    soft_pulse();
    chk("R8 word kept", tap_code, 8);

    // deselected activity is ignored
    inc_n = 1'b1; tick(4);
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    chk("R6 idle hold", tap_code, 8);

    // power-on reset discards the saved word
    por_n = 1'b0; tick(2); por_n = 1'b1; tick(5);
    chk("R1 default after por", tap_code, 5);
    soft_pulse();
    chk("R1 R10 word back to default", tap_code, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule